// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the register layer between software and a bank of DMA channel engines. Software accesses it through a 32-bit register port that reads and writes in one cycle. There are three live words. The first sets the transfer mode and direction of each channel. The second holds the per-channel interrupt enables and also takes start requests. The third shows the live state of every engine, together with sticky interrupt and error flags that software clears by writing ones.

The channel count is a parameter, and both a 4-channel build and an 8-channel build are supported. Toward the engines, the block drives a 2-bit mode and a direction bit for each channel, plus a single-cycle start pulse. From the engines it takes a 2-bit state code and done and error strobes. It combines the enabled interrupt flags into a single interrupt line.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset, every mode, direction, enable, start and flag bit is zero, and `irq_out` is low.
- R2: The word at 0x00 gives channel `c` the 4-bit field at bit `4*c`. Bits [1:0] of the field drive `eng_mode` (0 off, 1 scatter-gather, 2 one-shot), and bit 2 drives `eng_dir` (1 memory to device, 0 device to memory). Bit 3 of each field always reads zero.
- R3: Bits [NCH-1:0] of the word at 0x08 are the interrupt enables, and they read back as written. All other bits of that word read zero.
- R4: A write to 0x08 with bit `8+c` set raises `eng_start[c]` for exactly the cycle after the write, provided the channel is idle. The start bits never read back as one.
- R5: If `eng_state` of channel `c` is nonzero in the cycle of the write, a start request for that channel is dropped.
- R6: Bits [17+2c:16+2c] of the word at 0x10 show the live `eng_state` of channel `c` (0 idle, 1 descriptor fetch, 2 waiting, 3 transferring).
- R7: A done strobe sets bit `c` of the word at 0x10 (the interrupt flag). An error strobe sets both bit `c` and bit `8+c` (the error flag). Both flags are sticky.
- R8: Writing the word at 0x10 clears each flag whose bit is written as one and leaves flags written as zero unchanged. A strobe arriving in the same cycle as the clear wins, so the flag stays set.
- R9: `irq_out` is high exactly when some channel has both its interrupt flag and its enable set.
- R10: Addresses other than 0x00, 0x08 and 0x10 read zero, and writes to them change nothing. Only bits [1:0] of the address are ignored.
- R11: With NCH=4, the fields of channels 4 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| eng_state | input | 2*NCH | State code of each engine |
| eng_done | input | NCH | Completion strobe of each engine |
| eng_err | input | NCH | Error strobe of each engine |
| eng_mode | output | 2*NCH | Mode of each channel |
| eng_dir | output | NCH | Direction of each channel |
| eng_start | output | NCH | Single-cycle start pulse of each channel |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two things can land on the same channel flag in one cycle: an engine strobe setting it and a software write-one clearing it. The bench forces this collision deliberately by asserting `eng_done` on a channel in the same cycle as a clear write to 0x10, and expects the flag, and through it `irq_out`, to remain set. The same collision also occurs naturally during the long random phase, where strobes and clear writes are drawn independently. A start request that arrives while the engine state is busy is judged the same way, by looking for an absent pulse on `eng_start`.

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int NCH = 8,
  parameter int AW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [2*NCH-1:0] eng_state,
  input  logic [NCH-1:0]   eng_done,
  input  logic [NCH-1:0]   eng_err,
  output logic [2*NCH-1:0] eng_mode,
  output logic [NCH-1:0]   eng_dir,
  output logic [NCH-1:0]   eng_start,
  output logic             irq_out
);

  localparam logic [AW-3:0] W_CFG = (AW-2)'(0);
  localparam logic [AW-3:0] W_ENA = (AW-2)'(2);
  localparam logic [AW-3:0] W_FLG = (AW-2)'(4);

  logic [AW-3:0]    word;
  logic             wr_cfg, wr_ena, wr_flg;
  logic [3*NCH-1:0] cfg;
  logic [NCH-1:0]   ien, start_q, irq_f, err_f;
  logic [31:0]      cfg_v, flg_v;
  logic             unused_bits;

  assign word   = reg_addr[AW-1:2];
  assign wr_cfg = reg_wr && word == W_CFG;
  assign wr_ena = reg_wr && word == W_ENA;
  assign wr_flg = reg_wr && word == W_FLG;
  assign unused_bits = ^{reg_wdata, reg_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) ien <= '0;
    else if (wr_ena) ien <= reg_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[3*c +: 3] <= '0;
        start_q[c]    <= 1'b0;
        irq_f[c]      <= 1'b0;
        err_f[c]      <= 1'b0;
      end else begin
        if (wr_cfg) cfg[3*c +: 3] <= reg_wdata[4*c +: 3];
        start_q[c] <= wr_ena && reg_wdata[8+c] && eng_state[2*c +: 2] == 2'd0;
        irq_f[c]   <= (irq_f[c] && !(wr_flg && reg_wdata[c])) || eng_done[c] || eng_err[c];
        err_f[c]   <= (err_f[c] && !(wr_flg && reg_wdata[8+c])) || eng_err[c];
      end
    end

    assign eng_mode[2*c +: 2] = cfg[3*c +: 2];
    assign eng_dir[c]         = cfg[3*c+2];

    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[c] |-> $past(eng_state[2*c +: 2]) == 2'd0);

    p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[c] |-> $past(reg_wr && reg_addr[AW-1:2] == W_ENA && reg_wdata[8+c]));

    p_strobe_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && (eng_done[c] || eng_err[c])) |-> irq_f[c]);

    p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && eng_err[c]) |-> err_f[c]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && wr_flg && reg_wdata[c] && !eng_done[c] && !eng_err[c]) |-> !irq_f[c]);
  end

  assign eng_start = start_q;
  assign irq_out   = |(irq_f & ien);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_f != '0 && ien != '0));

  always_comb begin
    cfg_v = '0;
    flg_v = '0;
    for (int c = 0; c < NCH; c++) begin
      cfg_v[4*c +: 3]    = cfg[3*c +: 3];
      flg_v[c]           = irq_f[c];
      flg_v[8+c]         = err_f[c];
      flg_v[16+2*c +: 2] = eng_state[2*c +: 2];
    end
    case (word)
      W_CFG:   reg_rdata = cfg_v;
      W_ENA:   reg_rdata = 32'(ien);
      W_FLG:   reg_rdata = flg_v;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/tb_dma_ctrl_regs.sv
`timescale 1ns/1ps
module tb_dma_ctrl_regs;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata, rdata4;
  logic [15:0] eng_state = '0;
  logic [7:0]  eng_done = '0, eng_err = '0;
  logic [15:0] eng_mode;
  logic [7:0]  eng_dir, eng_start;
  logic        irq_out;
  logic [7:0]  mode4;
  logic [3:0]  dir4, start4;
  logic        irq4;

  int n_chk = 0, n_err = 0;

  logic [2:0] m_cfg [N];
  logic [7:0] m_en = '0, m_irq = '0, m_err = '0, m_start = '0;

  always #10 clk = ~clk;

  dma_ctrl_regs #(.NCH(8), .AW(8)) dut (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .eng_state, .eng_done, .eng_err, .eng_mode, .eng_dir, .eng_start, .irq_out);

  dma_ctrl_regs #(.NCH(4), .AW(8)) dut4 (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata(rdata4),
    .eng_state(8'h00), .eng_done(4'h0), .eng_err(4'h0),
    .eng_mode(mode4), .eng_dir(dir4), .eng_start(start4), .irq_out(irq4));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a[7:2])
      6'd0: for (int c = 0; c < N; c++) v[4*c +: 3] = m_cfg[c];
      6'd2: v[7:0] = m_en;
      6'd4: begin
        v[7:0] = m_irq; v[15:8] = m_err; v[31:16] = eng_state;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step();
    logic [7:0] w = reg_addr;
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      m_start[c] = reg_wr && w[7:2] == 6'd2 && reg_wdata[8+c] && eng_state[2*c +: 2] == 2'd0;
      if (reg_wr && w[7:2] == 6'd0) m_cfg[c] = reg_wdata[4*c +: 3];
      if (reg_wr && w[7:2] == 6'd4) begin
        if (reg_wdata[c])   m_irq[c] = 1'b0;
        if (reg_wdata[8+c]) m_err[c] = 1'b0;
      end
      if (eng_done[c] || eng_err[c]) m_irq[c] = 1'b1;
      if (eng_err[c]) m_err[c] = 1'b1;
    end
    if (reg_wr && w[7:2] == 6'd2) m_en = reg_wdata[7:0];
    @(negedge clk);
    begin
      logic [15:0] em; logic [7:0] ed;
      for (int c = 0; c < N; c++) begin
        em[2*c +: 2] = m_cfg[c][1:0]; ed[c] = m_cfg[c][2];
      end
      check("R2 eng_mode", 32'(eng_mode), 32'(em));
      check("R2 eng_dir", 32'(eng_dir), 32'(ed));
    end
    check("R4/R5 eng_start", 32'(eng_start), 32'(m_start));
    check("R9 irq_out", 32'(irq_out), 32'(|(m_irq & m_en)));
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    reg_wr = 0; reg_addr = a; #1;
    check(tag, reg_rdata, exp_read(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    step();
    reg_wr = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < N; c++) m_cfg[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check("R1 irq after reset", 32'(irq_out), 0);
    check("R1 start after reset", 32'(eng_start), 0);
    rd_chk(8'h00, "R1 cfg word");
    rd_chk(8'h08, "R1 enable word");
    rd_chk(8'h10, "R1 flag word");

    wr(8'h00, 32'hFEDC_BA98);
    rd_chk(8'h00, "R2 cfg readback");
    check("R2 bit3 zero", reg_rdata & 32'h8888_8888, 0);

    wr(8'h08, 32'hFFFF_00A5);
    rd_chk(8'h08, "R3 enable readback");
    check("R3 enable word", reg_rdata, 32'h0000_00A5);

    eng_state = 16'h0008;
    wr(8'h08, 32'h0000_0301);
    check("R4 start ch0 pulse", 32'(eng_start), 32'h1);
    check("R5 busy ch1 no start", 32'(eng_start[1]), 0);
    rd_chk(8'h08, "R4 start bits read zero");
    step();
    check("R4 start one cycle", 32'(eng_start), 0);

    eng_state = 16'hE4_1B;
    rd_chk(8'h10, "R6 live state");

    eng_done = 8'h01; step(); eng_done = 0;
    check("R9 irq with enable", 32'(irq_out), 1);
    eng_done = 8'h02; step(); eng_done = 0;
    rd_chk(8'h10, "R7 done flag ch1");

    eng_done = 8'h01;
    wr(8'h10, 32'h0000_0001);
    eng_done = 0;
    rd_chk(8'h10, "R8 set wins over clear");
    check("R8 collision irq held", 32'(irq_out), 1);
    wr(8'h10, 32'h0000_0001);
    rd_chk(8'h10, "R8 clear ch0");

    eng_err = 8'h08; step(); eng_err = 0;
    rd_chk(8'h10, "R7 error sets both");
    wr(8'h10, 32'h0000_0800);
    rd_chk(8'h10, "R8 clear err only");

    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h00, "R10 cfg untouched");
    rd_chk(8'h08, "R10 enable untouched");
    rd_chk(8'h10, "R10 flags untouched");
    rd_chk(8'h04, "R10 reserved zero");
    rd_chk(8'h20, "R10 descriptor zero");

    wr(8'h00, 32'hFFFF_FFFF);
    reg_addr = 8'h00; #1;
    check("R11 four-channel cfg", rdata4, 32'h0000_7777);
    wr(8'h08, 32'h0000_FFFF);
    reg_addr = 8'h08; #1;
    check("R11 four-channel enable", rdata4, 32'h0000_000F);
    check("R11 four-channel start", 32'(start4), 32'hF);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] addrs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h3C};
      eng_state = 16'($urandom);
      eng_done  = 8'($urandom & $urandom & $urandom);
      eng_err   = 8'($urandom & $urandom & $urandom & $urandom);
      reg_addr  = addrs[$urandom % 8];
      reg_wdata = $urandom;
      reg_wr    = ($urandom % 3) != 0;
      step();
      reg_wr = 0; eng_done = 0; eng_err = 0;
      rd_chk(addrs[$urandom % 8], "R6/R7/R8/R10 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule